// File: doc/BRIEF.md
# Receiver Power State Controller

This block picks the operating power state of a video/audio receiver. It combines four kinds of input. The first is an active-low power-down bit held in a control register. The second is an external power-down pin of programmable polarity, which arrives asynchronously. The third is a set of sync-activity flags from the input detectors. The last is an auto-power-down enable.

From these inputs the block produces three results, all registered:
- a two-bit state code;
- an enable vector with one bit per circuit group;
- a tristate control vector for the output groups.

An explicit power-down command always wins over the automatic, sync-driven choice. When the pin is asserted, a mode-select bit decides what it does. In one mode it powers the receiver down. In the other it only floats the outputs and leaves the state alone, with the sync-slicer output exempt.

The pin is resynchronised through a flop chain. It is then filtered, so that a level reaches the decision logic only after it has held for a programmable number of clocks. The register inputs act on the next clock edge. The state, the enable vector and the tristate vector are always updated together in that same cycle.

Top module: `rxpwr_ctrl`

## Requirements
- R1: While and directly after reset, `state_o` is 2'd1 (seek, all on), `grp_en_o` is all ones and `hiz_o` is all zeros.
- R2: State codes are 0 = full power, 1 = seek with all groups on, 2 = seek at reduced power, 3 = power-down. With no power-down command and sync detected, the next clock gives state 0 and `grp_en_o` all ones.
- R3: With no command, no sync and `auto_pd_en_i` low, the next clock gives state 1 with `grp_en_o` all ones.
- R4: With no command, no sync and `auto_pd_en_i` high, the next clock gives state 2. In that state `grp_en_o` is 7'b0001111: bit 0 is the serial bus, bit 1 activity detect, bit 2 the sync slicer and bit 3 the reference. Bit 4 (front end), bit 5 (video path) and bit 6 (audio) are off.
- R5: `pd_reg_n_i` = 0 gives state 3 and `grp_en_o` 7'b0001111 on the next clock, whatever the sync flags and the auto enable are.
- R6: An asserted pin with `pin_hiz_sel_i` = 0 gives state 3 with `grp_en_o` 7'b0001111, overriding sync detection.
- R7: An asserted pin with `pin_hiz_sel_i` = 1 leaves the state and enables to the automatic decision. It forces `hiz_o` bits 0 (video), 2 (S/PDIF) and 3 (I2S) high, and leaves bit 1 (sync slicer) under register control.
- R8: The pin counts as asserted when its filtered level equals `pin_pol_i`, so 1 means active high and 0 means active low. A change of `pin_pol_i` acts on the next clock.
- R9: A pin level takes effect only after it has held for DEB_LEN clocks behind the SYNC_STAGES-flop synchroniser. With the defaults, a change made between edges shows on the outputs at the 7th rising edge and not before. A pulse of 3 clocks has no effect.
- R10: Sync counts as detected when any one of the NUM_ACT activity flags is high. Each flag alone is sufficient.
- R11: Each bit of `hiz_req_i` drives the same bit of `hiz_o` on the next clock, in the order video, sync slicer, S/PDIF, I2S (bits 0 to 3).
- R12: All outputs are registered. A change of a register-sourced input reaches the state, enable and tristate outputs together on the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pd_reg_n_i | input | 1 | Register power-down bit, 0 commands power-down |
| pin_pd_i | input | 1 | External power-down pin, asynchronous |
| pin_pol_i | input | 1 | Pin polarity, 1 = active high |
| pin_hiz_sel_i | input | 1 | Pin action: 0 = power-down, 1 = float outputs except sync slicer |
| act_i | input | NUM_ACT (6) | Sync-activity flags |
| auto_pd_en_i | input | 1 | Enables reduced-power seek when no sync is seen |
| hiz_req_i | input | 4 | Register tristate requests: video, sync slicer, S/PDIF, I2S |
| state_o | output | 2 | Encoded power state |
| grp_en_o | output | 7 | Circuit group enables |
| hiz_o | output | 4 | Output group tristate controls |

## Verification
The bench builds the block with the default parameters: six activity flags, a two-flop synchroniser and a four-clock debounce. With these values the whole pin path spans seven edges, so the bench can check both sides of that window exactly. One check falls two edges before the pin takes effect and one falls on the edge where it does. A three-clock pulse lands one clock short of the filter length. Six flags are few enough to drive each one alone and show that every OR input is live.

// File: rtl/rxpwr_pkg.sv
// Package: shared encodings for the receiver power state controller.
// Assumes: group and tristate bit positions are fixed by downstream decoders.
package rxpwr_pkg;

    typedef enum logic [1:0] {
        PS_FULL     = 2'd0,
        PS_SEEK_ON  = 2'd1,
        PS_SEEK_LOW = 2'd2,
        PS_DOWN     = 2'd3
    } pwr_state_e;

    // Circuit group enable bit positions
    localparam int GRP_N      = 7;
    localparam int GRP_SERIAL = 0;
    localparam int GRP_ACTDET = 1;
    localparam int GRP_SLICER = 2;
    localparam int GRP_REF    = 3;
    localparam int GRP_FRONT  = 4;
    localparam int GRP_VIDEO  = 5;
    localparam int GRP_AUDIO  = 6;

    localparam logic [GRP_N-1:0] GRP_ALL = {GRP_N{1'b1}};
    localparam logic [GRP_N-1:0] GRP_AON = (GRP_N'(1) << GRP_SERIAL) |
                                           (GRP_N'(1) << GRP_ACTDET) |
                                           (GRP_N'(1) << GRP_SLICER) |
                                           (GRP_N'(1) << GRP_REF);

    // Output tristate bit positions
    localparam int HZ_N      = 4;
    localparam int HZ_VIDEO  = 0;
    localparam int HZ_SLICER = 1;
    localparam int HZ_SPDIF  = 2;
    localparam int HZ_I2S    = 3;

    localparam logic [HZ_N-1:0] HZ_PIN_MASK = (HZ_N'(1) << HZ_VIDEO) |
                                              (HZ_N'(1) << HZ_SPDIF) |
                                              (HZ_N'(1) << HZ_I2S);

endpackage

// File: rtl/rxpwr_pin_cond.sv
// Module: rxpwr_pin_cond
// Brings the asynchronous power-down pin into the clock domain through a
// flop chain. It then passes a new level only after that level has held
// for DEB_LEN consecutive clocks.
// Assumes: SYNC_STAGES >= 2 and DEB_LEN >= 2; the filtered level resets to 0.
module rxpwr_pin_cond #(
    parameter int SYNC_STAGES = 2,
    parameter int DEB_LEN     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async_i,
    output logic level_o
);
    localparam int CW = $clog2(DEB_LEN + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(DEB_LEN - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          cnt_q;
    logic                   level_q;
    logic                   synced;

    // Synchroniser chain, one flop per stage
    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                // First stage samples the raw pin
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= pin_async_i;
                end
            end else begin : g_next
                // Later stages shift the sampled value along
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    assign synced = sync_q[SYNC_STAGES-1];

    // Debounce: count clocks of disagreement, adopt the level after DEB_LEN
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            level_q <= 1'b0;
        end else if (synced == level_q) begin
            cnt_q   <= '0;
        end else if (cnt_q == CNT_LAST) begin
            cnt_q   <= '0;
            level_q <= synced;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    assign level_o = level_q;

endmodule

// File: rtl/rxpwr_decide.sv
// Module: rxpwr_decide
// Combinational choice of the next power state, group enables and
// tristate controls. Commands beat the automatic sync-based choice.
// Assumes: all inputs are already in the clock domain.
module rxpwr_decide
    import rxpwr_pkg::*;
#(
    parameter int NUM_ACT = 6
) (
    input  logic                pd_reg_n_i,
    input  logic                pin_on_i,
    input  logic                pin_hiz_sel_i,
    input  logic [NUM_ACT-1:0]  act_i,
    input  logic                auto_pd_en_i,
    input  logic [HZ_N-1:0]     hiz_req_i,
    output pwr_state_e          nxt_state_o,
    output logic [GRP_N-1:0]    nxt_en_o,
    output logic [HZ_N-1:0]     nxt_hiz_o
);
    logic sync_seen;
    logic pd_cmd;
    logic pin_float;

    // Any activity flag counts as sync
    assign sync_seen = |act_i;

    // Power-down command from register or pin in power-down mode
    assign pd_cmd    = !pd_reg_n_i || (pin_on_i && !pin_hiz_sel_i);

    // Pin in float mode forces the non-slicer outputs to high impedance
    assign pin_float = pin_on_i && pin_hiz_sel_i;

    // State priority: command, then sync, then auto power-down choice
    always_comb begin
        if (pd_cmd)            nxt_state_o = PS_DOWN;
        else if (sync_seen)    nxt_state_o = PS_FULL;
        else if (auto_pd_en_i) nxt_state_o = PS_SEEK_LOW;
        else                   nxt_state_o = PS_SEEK_ON;
    end

    // Group enables follow from the chosen state
    always_comb begin
        case (nxt_state_o)
            PS_FULL, PS_SEEK_ON:  nxt_en_o = GRP_ALL;
            default:              nxt_en_o = GRP_AON;
        endcase
    end

    // Tristate: register requests plus the pin float mask
    always_comb begin
        nxt_hiz_o = hiz_req_i | (pin_float ? HZ_PIN_MASK : '0);
    end

endmodule

// File: rtl/rxpwr_state_reg.sv
// Module: rxpwr_state_reg
// Registers the state, enables and tristate controls together so that
// they always change on the same edge.
// Assumes: reset state is seek with everything on and no output floated.
module rxpwr_state_reg
    import rxpwr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  pwr_state_e       nxt_state_i,
    input  logic [GRP_N-1:0] nxt_en_i,
    input  logic [HZ_N-1:0]  nxt_hiz_i,
    output pwr_state_e       state_o,
    output logic [GRP_N-1:0] en_o,
    output logic [HZ_N-1:0]  hiz_o
);
    // Single output register stage for all three vectors
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_o <= PS_SEEK_ON;
            en_o    <= GRP_ALL;
            hiz_o   <= '0;
        end else begin
            state_o <= nxt_state_i;
            en_o    <= nxt_en_i;
            hiz_o   <= nxt_hiz_i;
        end
    end

endmodule

// File: rtl/rxpwr_ctrl.sv
// Module: rxpwr_ctrl (top)
// Receiver power state controller: conditions the power-down pin, applies
// its polarity, decides the state and registers the outputs.
// Assumes: every input except pin_pd_i comes from registers in clk's domain.
module rxpwr_ctrl
    import rxpwr_pkg::*;
#(
    parameter int NUM_ACT     = 6,
    parameter int SYNC_STAGES = 2,
    parameter int DEB_LEN     = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pd_reg_n_i,
    input  logic               pin_pd_i,
    input  logic               pin_pol_i,
    input  logic               pin_hiz_sel_i,
    input  logic [NUM_ACT-1:0] act_i,
    input  logic               auto_pd_en_i,
    input  logic [3:0]         hiz_req_i,
    output logic [1:0]         state_o,
    output logic [6:0]         grp_en_o,
    output logic [3:0]         hiz_o
);
    logic       pin_level;
    logic       pin_on;
    pwr_state_e nxt_state;
    pwr_state_e cur_state;
    logic [GRP_N-1:0] nxt_en;
    logic [HZ_N-1:0]  nxt_hiz;

    rxpwr_pin_cond #(
        .SYNC_STAGES (SYNC_STAGES),
        .DEB_LEN     (DEB_LEN)
    ) u_pin (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_async_i (pin_pd_i),
        .level_o     (pin_level)
    );

    // Pin is asserted when its filtered level matches the polarity bit
    assign pin_on = (pin_level == pin_pol_i);

    rxpwr_decide #(
        .NUM_ACT (NUM_ACT)
    ) u_decide (
        .pd_reg_n_i    (pd_reg_n_i),
        .pin_on_i      (pin_on),
        .pin_hiz_sel_i (pin_hiz_sel_i),
        .act_i         (act_i),
        .auto_pd_en_i  (auto_pd_en_i),
        .hiz_req_i     (hiz_req_i),
        .nxt_state_o   (nxt_state),
        .nxt_en_o      (nxt_en),
        .nxt_hiz_o     (nxt_hiz)
    );

    rxpwr_state_reg u_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .nxt_state_i (nxt_state),
        .nxt_en_i    (nxt_en),
        .nxt_hiz_i   (nxt_hiz),
        .state_o     (cur_state),
        .en_o        (grp_en_o),
        .hiz_o       (hiz_o)
    );

    assign state_o = cur_state;

endmodule

// File: rtl/rxpwr_ctrl_chk.sv
// Module: rxpwr_ctrl_chk
// Checker bound to rxpwr_ctrl. It relates the command inputs and the
// filtered pin to the registered outputs one clock later.
// Assumes: the bind supplies the top's internal pin_on signal.
module rxpwr_ctrl_chk #(
    parameter int NUM_ACT = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pd_reg_n_i,
    input logic               pin_on,
    input logic               pin_hiz_sel_i,
    input logic [NUM_ACT-1:0] act_i,
    input logic [1:0]         state_o,
    input logic [6:0]         grp_en_o,
    input logic [3:0]         hiz_o
);
    // R5: register command forces power-down with only the kept groups on
    a_r5_reg_pd: assert property (@(posedge clk) disable iff (!rst_n)
        !pd_reg_n_i |=> (state_o == 2'd3) && (grp_en_o == 7'b0001111));

    // R6: pin in power-down mode overrides sync detection
    a_r6_pin_pd: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_on && !pin_hiz_sel_i) |=> (state_o == 2'd3));

    // R2: no command and sync seen gives full power, all groups on
    a_r2_sync_full: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_reg_n_i && !(pin_on && !pin_hiz_sel_i) && (|act_i))
        |=> (state_o == 2'd0) && (&grp_en_o));

    // R4: reduced-power seek keeps exactly the always-on groups
    a_r4_seek_low_en: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd2) |-> (grp_en_o == 7'b0001111));

    // R7: pin in float mode floats video, S/PDIF and I2S
    a_r7_pin_float: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_on && pin_hiz_sel_i) |=> (hiz_o[0] && hiz_o[2] && hiz_o[3]));

endmodule

bind rxpwr_ctrl rxpwr_ctrl_chk #(.NUM_ACT(NUM_ACT)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pd_reg_n_i    (pd_reg_n_i),
    .pin_on        (pin_on),
    .pin_hiz_sel_i (pin_hiz_sel_i),
    .act_i         (act_i),
    .state_o       (state_o),
    .grp_en_o      (grp_en_o),
    .hiz_o         (hiz_o)
);

// File: tb/rxpwr_ctrl_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: stimulus tasks queue expected outputs with a due cycle,
// a monitor compares them against the ports shortly after the falling edge.
module rxpwr_ctrl_tb;

    localparam logic [6:0] EN_ALL = 7'b1111111;
    localparam logic [6:0] EN_AON = 7'b0001111;

    typedef struct {
        int         due;
        logic [1:0] st;
        logic [6:0] en;
        logic [3:0] hz;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pd_reg_n_i = 1'b1;
    logic       pin_pd_i = 1'b0;
    logic       pin_pol_i = 1'b1;
    logic       pin_hiz_sel_i = 1'b0;
    logic [5:0] act_i = '0;
    logic       auto_pd_en_i = 1'b0;
    logic [3:0] hiz_req_i = '0;
    logic [1:0] state_o;
    logic [6:0] grp_en_o;
    logic [3:0] hiz_o;

    int   cyc = 0;
    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;
    exp_t q[$];

    rxpwr_ctrl u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .pd_reg_n_i    (pd_reg_n_i),
        .pin_pd_i      (pin_pd_i),
        .pin_pol_i     (pin_pol_i),
        .pin_hiz_sel_i (pin_hiz_sel_i),
        .act_i         (act_i),
        .auto_pd_en_i  (auto_pd_en_i),
        .hiz_req_i     (hiz_req_i),
        .state_o       (state_o),
        .grp_en_o      (grp_en_o),
        .hiz_o         (hiz_o)
    );

    // 125 MHz clock
    always #4 clk = ~clk;

    // Cycle counter used for due times
    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: pop every item that is due and compare with the ports
    always @(negedge clk) begin
        #1;
        while (q.size() > 0 && q[0].due <= cyc) begin
            exp_t e;
            e = q.pop_front();
            total++;
            if (state_o !== e.st || grp_en_o !== e.en || hiz_o !== e.hz) begin
                bad++;
                $display("FAIL %s: got st=%0d en=%b hz=%b expected st=%0d en=%b hz=%b",
                         e.tag, state_o, grp_en_o, hiz_o, e.st, e.en, e.hz);
            end
        end
    end

    task automatic push(input int d, input logic [1:0] st, input logic [6:0] en,
                        input logic [3:0] hz, input string tag);
        exp_t e;
        e.due = cyc + d; e.st = st; e.en = en; e.hz = hz; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as one failure and still reports
    initial begin
        #200000;
        if (!done) begin
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(3);
        // R1: reset value, checked before any active edge
        push(0, 2'd1, EN_ALL, 4'b0000, "R1 reset during");
        step(1);
        rst_n = 1'b1;
        push(0, 2'd1, EN_ALL, 4'b0000, "R1 reset released");
        step(2);

        // R2/R12: sync on flag 0 gives full power one edge later
        act_i = 6'b000001;
        push(1, 2'd0, EN_ALL, 4'b0000, "R2 R12 sync full");
        step(2);

        // R10/R3: each flag alone detects sync
        for (int i = 0; i < 6; i++) begin
            act_i = '0;
            push(1, 2'd1, EN_ALL, 4'b0000, "R3 no sync seek on");
            step(2);
            act_i = 6'(1) << i;
            push(1, 2'd0, EN_ALL, 4'b0000, $sformatf("R10 flag %0d", i));
            step(2);
        end

        // R4: no sync with auto enable gives reduced seek
        act_i = '0;
        auto_pd_en_i = 1'b1;
        push(1, 2'd2, EN_AON, 4'b0000, "R4 seek low");
        step(2);
        auto_pd_en_i = 1'b0;
        push(1, 2'd1, EN_ALL, 4'b0000, "R3 auto off");
        step(2);

        // R5: register command overrides sync
        auto_pd_en_i = 1'b1;
        act_i = 6'b100000;
        pd_reg_n_i = 1'b0;
        push(1, 2'd3, EN_AON, 4'b0000, "R5 reg pd");
        step(2);
        pd_reg_n_i = 1'b1;
        push(1, 2'd0, EN_ALL, 4'b0000, "R5 reg pd release");
        step(2);

        // R11: tristate requests map bit for bit
        hiz_req_i = 4'b0101;
        push(1, 2'd0, EN_ALL, 4'b0101, "R11 hz 0101");
        step(2);
        hiz_req_i = 4'b1010;
        push(1, 2'd0, EN_ALL, 4'b1010, "R11 hz 1010");
        step(2);
        hiz_req_i = 4'b0000;
        push(1, 2'd0, EN_ALL, 4'b0000, "R11 hz clear");
        step(2);

        // R6/R9: pin power-down appears on the 7th edge, not the 5th
        pin_pd_i = 1'b1;
        push(5, 2'd0, EN_ALL, 4'b0000, "R9 pin not yet");
        push(7, 2'd3, EN_AON, 4'b0000, "R6 R9 pin pd");
        step(8);
        pin_pd_i = 1'b0;
        push(5, 2'd3, EN_AON, 4'b0000, "R9 pin release not yet");
        push(7, 2'd0, EN_ALL, 4'b0000, "R9 pin release");
        step(8);

        // R9: a 3-clock pulse is filtered out
        pin_pd_i = 1'b1;
        for (int k = 1; k <= 10; k++)
            push(k, 2'd0, EN_ALL, 4'b0000, "R9 short pulse ignored");
        step(3);
        pin_pd_i = 1'b0;
        step(8);

        // R7: pin in float mode keeps the automatic state
        act_i = '0;
        pin_hiz_sel_i = 1'b1;
        push(1, 2'd2, EN_AON, 4'b0000, "R4 seek low again");
        step(2);
        pin_pd_i = 1'b1;
        push(7, 2'd2, EN_AON, 4'b1101, "R7 float in seek low");
        step(8);
        act_i = 6'b000100;
        push(1, 2'd0, EN_ALL, 4'b1101, "R7 float in full");
        step(2);
        hiz_req_i = 4'b0010;
        push(1, 2'd0, EN_ALL, 4'b1111, "R7 R11 slicer by register");
        step(2);

        // R8: polarity flip releases the pin on the next edge
        pin_pol_i = 1'b0;
        push(1, 2'd0, EN_ALL, 4'b0010, "R8 polarity flip");
        step(2);
        hiz_req_i = 4'b0000;
        pin_pd_i = 1'b0;
        push(7, 2'd0, EN_ALL, 4'b1101, "R8 active low pin");
        step(8);
        pin_hiz_sel_i = 1'b0;
        push(1, 2'd3, EN_AON, 4'b0000, "R6 R8 active low pd");
        step(2);
        pin_pd_i = 1'b1;
        push(7, 2'd0, EN_ALL, 4'b0000, "R8 active low release");
        step(10);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule